// File: doc/BRIEF.md
# Inverter Bridge Gate Guard

This block sits between a motor controller and the gate drivers of a three-phase inverter bridge with an extra brake switch. Each phase has an upper and a lower switch, each commanded by an active-low input. The block passes those commands through to active-high gate enables one clock later. It blocks any command that would switch both devices of one phase on at once. It also cuts off any switch whose current-sense input has stayed high for too long.

A command that turns on both switches of a phase latches that phase off and raises a single fault flag. The latch releases only after each of the two phase inputs has made a fresh high-to-low transition. The release comes on the later of those two transitions. The brake gate has no protection: it follows its command unconditionally. An over-current trip affects only the switch that sensed it. It clears when that switch's command goes inactive, so each new command pulse starts clean.

Top module: `inv_gate_guard`

## Requirements
- R1: Each gate output (`gate_hi[p]`, `gate_lo[p]`) is the inverse of its active-low command input, registered, so it changes on the first rising clock edge after the input changes. Bit p of every per-phase vector belongs to phase p.
- R2: When `hi_cmd_n[p]` and `lo_cmd_n[p]` are both low at a clock edge, both gates of phase p are off from that edge on. The other phases keep following their commands.
- R3: `fault` is a registered OR of every interlock latch and every over-current latch. It rises on the same edge that sets a latch and falls on the edge that clears the last one.
- R4: Once a phase is interlocked, it stays off with `fault` high when its inputs return to a legal combination, including both high.
- R5: An interlocked phase is released only on the edge at which the second of its two inputs shows a high-to-low transition since the latch was set, with the other input high. Its gates then follow the commands again from that edge. Both inputs low at the same time restarts the wait.
- R6: `gate_brk` is always the registered inverse of `brk_cmd_n`. Neither interlocks nor over-current trips affect it.
- R7: A switch whose sense input has been high on SC_DELAY consecutive clock edges (default 8) is turned off on the SC_DELAY-th edge, and `fault` rises. All other switches are unaffected.
- R8: An over-current latch holds the switch off while its command stays low, even after the sense input drops. It clears, together with its share of `fault`, on the edge at which that switch's command input is high. A new low command then turns the gate back on.
- R9: A sense input that drops before SC_DELAY consecutive high edges has no effect, and its count restarts from zero.
- R10: Synchronous active-high `rst` holds all gates off and `fault` low. A phase whose inputs are both low when reset is released is interlocked on the first edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hi_cmd_n | input | N_PH | Upper-switch commands, active low, one bit per phase |
| lo_cmd_n | input | N_PH | Lower-switch commands, active low, one bit per phase |
| brk_cmd_n | input | 1 | Brake-switch command, active low |
| sc_hi | input | N_PH | Synchronized over-current sense, upper switches |
| sc_lo | input | N_PH | Synchronized over-current sense, lower switches |
| gate_hi | output | N_PH | Upper gate enables, active high |
| gate_lo | output | N_PH | Lower gate enables, active high |
| gate_brk | output | 1 | Brake gate enable, active high |
| fault | output | 1 | Fault flag, active high |

## Verification
All outputs are registered from next-state logic, so every effect of a command change, a shoot-through command, a release edge or a reset lands on the first rising edge after the stimulus. The bench drives inputs on the falling edge and samples one full cycle later, on the next falling edge. An over-current trip lands on the SC_DELAY-th edge with the sense input high. The bench steps SC_DELAY-1 edges and checks that nothing has happened yet, then steps once more and checks for the trip. The glitch case uses one low sample between two bursts of SC_DELAY-1 high samples.

// File: rtl/inv_prot_pkg.sv
package inv_prot_pkg;
  localparam int DEF_PHASES   = 3;
  localparam int DEF_SC_DELAY = 8;

  function automatic int cnt_width(input int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/phase_interlock.sv
module phase_interlock (
  input  logic clk,
  input  logic rst,
  input  logic hi_n,
  input  logic lo_n,
  output logic lock_d
);
  logic lock_q, prev_hi, prev_lo, seen_hi_q, seen_lo_q;
  logic fall_hi, fall_lo, both_on, seen_hi, seen_lo, release_now;

  always_comb begin
    fall_hi     = prev_hi & ~hi_n;
    fall_lo     = prev_lo & ~lo_n;
    both_on     = ~hi_n & ~lo_n;
    seen_hi     = seen_hi_q | fall_hi;
    seen_lo     = seen_lo_q | fall_lo;
    release_now = lock_q & seen_hi & seen_lo & (fall_hi | fall_lo);
    lock_d      = both_on | (lock_q & ~release_now);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q    <= 1'b0;
      prev_hi   <= 1'b1;
      prev_lo   <= 1'b1;
      seen_hi_q <= 1'b0;
      seen_lo_q <= 1'b0;
    end else begin
      lock_q  <= lock_d;
      prev_hi <= hi_n;
      prev_lo <= lo_n;
      if (lock_d && lock_q && !both_on) begin
        seen_hi_q <= seen_hi;
        seen_lo_q <= seen_lo;
      end else begin
        seen_hi_q <= 1'b0;
        seen_lo_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sc_guard.sv
module sc_guard #(
  parameter int SC_DELAY = inv_prot_pkg::DEF_SC_DELAY
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd_n,
  input  logic sense,
  output logic trip_d
);
  localparam int CW = inv_prot_pkg::cnt_width(SC_DELAY);
  localparam logic [CW-1:0] LAST = CW'(SC_DELAY - 1);

  logic [CW-1:0] cnt_q;
  logic          latch_q, fire;

  always_comb begin
    fire   = sense & (cnt_q >= LAST);
    trip_d = (latch_q | fire) & ~cmd_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      latch_q <= 1'b0;
    end else begin
      latch_q <= trip_d;
      if (!sense)
        cnt_q <= '0;
      else if (cnt_q < LAST)
        cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/inv_gate_guard.sv
module inv_gate_guard #(
  parameter int N_PH     = inv_prot_pkg::DEF_PHASES,
  parameter int SC_DELAY = inv_prot_pkg::DEF_SC_DELAY
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_PH-1:0] hi_cmd_n,
  input  logic [N_PH-1:0] lo_cmd_n,
  input  logic            brk_cmd_n,
  input  logic [N_PH-1:0] sc_hi,
  input  logic [N_PH-1:0] sc_lo,
  output logic [N_PH-1:0] gate_hi,
  output logic [N_PH-1:0] gate_lo,
  output logic            gate_brk,
  output logic            fault
);
  logic [N_PH-1:0] lock_d, trip_hi_d, trip_lo_d;

  for (genvar p = 0; p < N_PH; p++) begin : g_phase
    phase_interlock u_lock (
      .clk (clk), .rst (rst),
      .hi_n(hi_cmd_n[p]), .lo_n(lo_cmd_n[p]),
      .lock_d(lock_d[p])
    );
    sc_guard #(.SC_DELAY(SC_DELAY)) u_sc_hi (
      .clk(clk), .rst(rst), .cmd_n(hi_cmd_n[p]), .sense(sc_hi[p]), .trip_d(trip_hi_d[p])
    );
    sc_guard #(.SC_DELAY(SC_DELAY)) u_sc_lo (
      .clk(clk), .rst(rst), .cmd_n(lo_cmd_n[p]), .sense(sc_lo[p]), .trip_d(trip_lo_d[p])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_hi  <= '0;
      gate_lo  <= '0;
      gate_brk <= 1'b0;
      fault    <= 1'b0;
    end else begin
      gate_hi  <= ~hi_cmd_n & ~lock_d & ~trip_hi_d;
      gate_lo  <= ~lo_cmd_n & ~lock_d & ~trip_lo_d;
      gate_brk <= ~brk_cmd_n;
      fault    <= (|lock_d) | (|trip_hi_d) | (|trip_lo_d);
    end
  end
endmodule

// File: rtl/inv_gate_guard_chk.sv
module inv_gate_guard_chk #(
  parameter int N_PH = 3
) (
  input logic            clk,
  input logic            rst,
  input logic [N_PH-1:0] hi_cmd_n,
  input logic [N_PH-1:0] lo_cmd_n,
  input logic            brk_cmd_n,
  input logic [N_PH-1:0] gate_hi,
  input logic [N_PH-1:0] gate_lo,
  input logic            gate_brk,
  input logic            fault
);
  for (genvar p = 0; p < N_PH; p++) begin : g_ph
    AST_SHOOT_BLOCK: assert property (@(posedge clk) disable iff (rst)
      (!hi_cmd_n[p] && !lo_cmd_n[p]) |=> (!gate_hi[p] && !gate_lo[p] && fault)); // R2
    AST_HI_NEEDS_CMD: assert property (@(posedge clk) disable iff (rst)
      (!rst && hi_cmd_n[p]) |=> !gate_hi[p]); // R1
    AST_LO_NEEDS_CMD: assert property (@(posedge clk) disable iff (rst)
      (!rst && lo_cmd_n[p]) |=> !gate_lo[p]); // R1
  end

  AST_BRAKE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (gate_brk == !$past(brk_cmd_n))); // R6

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!fault && !gate_brk && gate_hi == '0 && gate_lo == '0)); // R10
endmodule

bind inv_gate_guard inv_gate_guard_chk #(.N_PH(N_PH)) u_chk (
  .clk(clk), .rst(rst), .hi_cmd_n(hi_cmd_n), .lo_cmd_n(lo_cmd_n),
  .brk_cmd_n(brk_cmd_n), .gate_hi(gate_hi), .gate_lo(gate_lo),
  .gate_brk(gate_brk), .fault(fault)
);

// File: tb/inv_gate_guard_test.sv
`timescale 1ns/1ps
module inv_gate_guard_test;
  localparam int NP  = 3;
  localparam int DLY = 8;
  localparam int NV  = 16;

  // {hi_n[2:0], lo_n[2:0], brk_n, exp gate_hi[2:0], exp gate_lo[2:0], exp gate_brk, exp fault}
  localparam logic [14:0] VEC [NV] = '{
    15'b111_111_1_000_000_0_0,
    15'b110_111_1_001_000_0_0,
    15'b110_101_0_001_010_1_0,
    15'b110_100_0_000_010_1_1,
    15'b111_101_0_000_010_1_1,
    15'b111_100_0_000_010_1_1,
    15'b111_101_0_000_010_1_1,
    15'b110_101_0_001_010_1_0,
    15'b111_111_1_000_000_0_0,
    15'b011_111_1_100_000_0_0,
    15'b011_011_1_000_000_0_1,
    15'b111_111_1_000_000_0_1,
    15'b011_111_1_000_000_0_1,
    15'b111_111_1_000_000_0_1,
    15'b111_011_1_000_100_0_0,
    15'b111_111_1_000_000_0_0
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP-1:0] hi_cmd_n = '1, lo_cmd_n = '1, sc_hi = '0, sc_lo = '0;
  logic brk_cmd_n = 1'b1;
  logic [NP-1:0] gate_hi, gate_lo;
  logic gate_brk, fault;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  inv_gate_guard #(.N_PH(NP), .SC_DELAY(DLY)) uut (
    .clk(clk), .rst(rst), .hi_cmd_n(hi_cmd_n), .lo_cmd_n(lo_cmd_n),
    .brk_cmd_n(brk_cmd_n), .sc_hi(sc_hi), .sc_lo(sc_lo),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .gate_brk(gate_brk), .fault(fault)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] outs();
    return {gate_hi, gate_lo, gate_brk, fault};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    step();
    check("R10 outputs held in reset", outs(), 8'b000_000_0_0);
    rst = 1'b0;
    step();

    // R1 R2 R3 R4 R5 R6: command table
    for (int i = 0; i < NV; i++) begin
      {hi_cmd_n, lo_cmd_n, brk_cmd_n} = VEC[i][14:8];
      step();
      check($sformatf("R1/R2/R3/R4/R5/R6 row %0d", i), outs(), VEC[i][7:0]);
    end

    // R7 R8: over-current on phase1 upper, phase0 lower running
    hi_cmd_n = 3'b101; lo_cmd_n = 3'b110;
    step();
    check("R1 both switches on", outs(), 8'b010_001_0_0);
    sc_hi = 3'b010;
    repeat (DLY - 1) step();
    check("R7 no trip before delay", outs(), 8'b010_001_0_0);
    step();
    check("R7 trip at delay, only that switch", outs(), 8'b000_001_0_1);
    sc_hi = '0;
    step();
    check("R8 trip holds while command low", outs(), 8'b000_001_0_1);
    hi_cmd_n = 3'b111;
    step();
    check("R8 clears on command high", outs(), 8'b000_001_0_0);
    hi_cmd_n = 3'b101;
    step();
    check("R8 next pulse turns on", outs(), 8'b010_001_0_0);

    // R9: short bursts never trip
    sc_lo = 3'b001;
    repeat (DLY - 1) step();
    sc_lo = '0;
    step();
    sc_lo = 3'b001;
    repeat (DLY - 1) step();
    check("R9 interrupted sense has no effect", outs(), 8'b010_001_0_0);
    step();
    check("R7 lower switch trips after restarted count", outs(), 8'b010_000_0_1);
    sc_lo = '0; lo_cmd_n = 3'b111; hi_cmd_n = 3'b111;
    step();
    check("R8 lower trip cleared", outs(), 8'b000_000_0_0);

    // R10: reset with phase2 shoot-through pending
    rst = 1'b1; hi_cmd_n = 3'b011; lo_cmd_n = 3'b011; brk_cmd_n = 1'b0;
    step();
    check("R10 reset overrides commands", outs(), 8'b000_000_0_0);
    rst = 1'b0;
    step();
    check("R10 interlock on first clock after reset", outs(), 8'b000_000_1_1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule